// File: doc/BRIEF.md
# Coincident-Edge Sync Pulse Generator

This block runs in the source clock domain of a clock divider with two output banks, A and C. Each bank divides the source clock by its own ratio. The block follows where each bank sits in its divide cycle. It predicts the next source cycle on which both banks produce a rising edge together, and it drives an active-low sync output that warns of that shared edge ahead of time.

The warning starts a fixed number of source cycles before the shared edge. That number is the period of the faster bank, trimmed if needed so that the output always has a high cycle. The output goes high again on the very cycle where the two rising edges line up. Shared edges repeat every least common multiple of the two ratios. The two ratios do not have to be integer multiples of each other (for example 4:3 or 3:2).

Cycle numbering starts at reset release. Source cycle t = 0 is the cycle held in reset, and it counts as a shared edge. A bank with divide D has its rising edges on every cycle where t mod D equals 0. A change of either ratio select restarts this numbering from 0.

Top module: `coinc_sync_gen`

## Requirements
- R1: `sel_a` sets the divide of bank A: 0 gives 4, 1 gives 6, 2 gives 8 and 3 gives 12 source cycles.
- R2: `sel_c` sets the divide of bank C: 0 gives 2, 1 gives 4, 2 gives 6 and 3 gives 8 source cycles.
- R3: Let L be the least common multiple of the two divides. Shared rising edges fall on the cycles where t mod L equals 0. The output pattern repeats with period L for as long as the selects are unchanged.
- R4: The output is low exactly on the cycles with L − W ≤ (t mod L) ≤ L − 1. Here W is the smaller of the two divides, limited to at most L − 1.
- R5: On every shared-edge cycle ((t mod L) = 0) the output is high, and it rises only on such a cycle.
- R6: While `rst_n` is low on a clock edge, the output is high. After release the output stays high until the first warning window opens.
- R7: If either select differs from the value in use at a clock edge, that edge restarts the numbering at t = 0 with the new divides. The output is high on that cycle.
- R8: When both divides are equal (1:1), W is L − 1. The output is then high only on each shared-edge cycle and low on every other cycle.
- R9: Ratio pairs that are not integer multiples of each other follow R3 and R4 unchanged. Examples are A ÷6 with C ÷8 (L = 24, low for t mod 24 from 18 to 23) and A ÷6 with C ÷4 (L = 12, low from 8 to 11).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock shared by both banks |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_a | input | 2 | Bank A divide select |
| sel_c | input | 2 | Bank C divide select |
| sync_n | output | 1 | Active-low warning of the next shared rising edge |

## Verification
The bench predicts the output on every cycle from the least common multiple and the warning width, and compares each cycle against that prediction. It covers the 1:1 case, where a design that does not clip the window would hold the output low through the shared edge. It also covers the non-integer pairs 4:3 and 3:2, where a design that uses the larger divide in place of the least common multiple would warn at the wrong edges.

A select change in the middle of a warning window must pull the output high at once. A design that ignored the restart would keep the old phase. A reset in the middle of a run must hold the output high through a long warning-free stretch. Both of these are exercised.

// File: rtl/csync_pkg.sv
// Shared constants and decode functions for the coincident-edge sync generator.
// Assumes divides are small positive integers; all tables are computed.
package csync_pkg;

    localparam int SEL_W   = 2;
    localparam int DIV_MAX = 12;
    localparam int LCM_MAX = 24;
    localparam int DIV_W   = $clog2(DIV_MAX + 1);
    localparam int CNT_W   = $clog2(LCM_MAX + 1);

    // Bank A divide for a select value: 4, 6, 8, 12.
    function automatic logic [DIV_W-1:0] a_div(input logic [SEL_W-1:0] s);
        case (s)
            2'd0:    return DIV_W'(4);
            2'd1:    return DIV_W'(6);
            2'd2:    return DIV_W'(8);
            default: return DIV_W'(12);
        endcase
    endfunction

    // Bank C divide for a select value: 2, 4, 6, 8.
    function automatic logic [DIV_W-1:0] c_div(input logic [SEL_W-1:0] s);
        case (s)
            2'd0:    return DIV_W'(2);
            2'd1:    return DIV_W'(4);
            2'd2:    return DIV_W'(6);
            default: return DIV_W'(8);
        endcase
    endfunction

    // Least common multiple by search for the smallest common multiple.
    function automatic logic [CNT_W-1:0] lcm_of(input logic [DIV_W-1:0] x,
                                                 input logic [DIV_W-1:0] y);
        logic [CNT_W-1:0] r;
        r = CNT_W'(LCM_MAX);
        for (int k = LCM_MAX; k >= 1; k--) begin
            if ((k % int'(x)) == 0 && (k % int'(y)) == 0)
                r = CNT_W'(k);
        end
        return r;
    endfunction

    // Warning width: faster bank period, clipped to span-1.
    function automatic logic [CNT_W-1:0] win_of(input logic [DIV_W-1:0] x,
                                                 input logic [DIV_W-1:0] y,
                                                 input logic [CNT_W-1:0] span);
        logic [CNT_W-1:0] m;
        m = (x < y) ? CNT_W'(x) : CNT_W'(y);
        return (m < span) ? m : span - CNT_W'(1);
    endfunction

endpackage

// File: rtl/csync_cfg.sv
// Ratio configuration stage. Holds the selects in use, decodes both divides,
// the coincidence span and the warning width into registers, and flags a
// restart whenever an incoming select differs from the one in use.
// Assumes selects are synchronous to clk.
module csync_cfg
    import csync_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int DW = DIV_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sel_a,
    input  logic [SW-1:0] sel_c,
    output logic [DW-1:0] div_a,
    output logic [DW-1:0] div_c,
    output logic [CW-1:0] span,
    output logic [CW-1:0] win,
    output logic          restart
);

    logic [SW-1:0]    sel_a_q;
    logic [SW-1:0]    sel_c_q;
    logic [DIV_W-1:0] da_d;
    logic [DIV_W-1:0] dc_d;
    logic [CNT_W-1:0] span_d;

    // Detect a select change against the configuration in use.
    always_comb begin
        restart = (sel_a != sel_a_q) || (sel_c != sel_c_q);
        da_d    = a_div(SEL_W'(sel_a));
        dc_d    = c_div(SEL_W'(sel_c));
        span_d  = lcm_of(da_d, dc_d);
    end

    // Load a new configuration during reset or on a select change.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            sel_a_q <= sel_a;
            sel_c_q <= sel_c;
            div_a   <= DW'(da_d);
            div_c   <= DW'(dc_d);
            span    <= CW'(span_d);
            win     <= CW'(win_of(da_d, dc_d, span_d));
        end
    end

endmodule

// File: rtl/csync_phase.sv
// Modulo phase counter: counts 0..modulus-1 in source cycles, forced to zero
// on reset and on restart. Exposes the next value for registered consumers.
// Assumes modulus is at least 1 and changes only on a restart edge.
module csync_phase #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] modulus,
    output logic [W-1:0] ph,
    output logic [W-1:0] ph_next
);

    // Next phase: wrap at modulus-1, zero on restart.
    always_comb begin
        if (restart)
            ph_next = '0;
        else if (ph == modulus - W'(1))
            ph_next = '0;
        else
            ph_next = ph + W'(1);
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph <= '0;
        else
            ph <= ph_next;
    end

    AST_PH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ph < modulus); // R3

endmodule

// File: rtl/csync_shaper.sv
// Output shaper. Registers the active-low sync signal from the next span
// position: low inside the warning window that ends at the span wrap, high on
// the shared-edge cycle, high on any restart.
// Assumes win < span so a high cycle always exists.
module csync_shaper #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          coinc_now,
    input  logic          coinc_next,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cnt_next,
    input  logic [CW-1:0] span,
    input  logic [CW-1:0] win,
    output logic          sync_n
);

    logic [CW-1:0] thr;
    logic          sync_d;

    // Window opening position and next output value.
    always_comb begin
        thr    = span - win;
        sync_d = restart || coinc_next || (cnt_next < thr);
    end

    // Output register, high in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_n <= 1'b1;
        else
            sync_n <= sync_d;
    end

    AST_WIN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_n) |-> (cnt == span - win)); // R4
    AST_RISE_ON_COINC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n) |-> coinc_now); // R5
    AST_HIGH_ON_COINC: assert property (@(posedge clk) disable iff (!rst_n)
        coinc_now |-> sync_n); // R5
    AST_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (sync_n && coinc_now)); // R7

endmodule

// File: rtl/coinc_sync_gen.sv
// Coincident-edge sync generator top. Tracks the phase of bank A and bank C
// and the least-common-multiple span, and drives sync_n low for the warning
// window before each shared rising edge.
// Assumes one source clock for both banks; selects synchronous to clk.
module coinc_sync_gen
    import csync_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int DW = DIV_W,
    parameter int CW = CNT_W,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sel_a,
    input  logic [SW-1:0] sel_c,
    output logic          sync_n
);

    logic [DW-1:0] div_a;
    logic [DW-1:0] div_c;
    logic [CW-1:0] span;
    logic [CW-1:0] win;
    logic          restart;
    logic [DW-1:0] bank_div [NB];
    logic [DW-1:0] bank_ph  [NB];
    logic [DW-1:0] bank_nx  [NB];
    logic [CW-1:0] span_cnt;
    logic [CW-1:0] span_nx;
    logic          coinc_now;
    logic          coinc_next;

    csync_cfg #(.SW(SW), .DW(DW), .CW(CW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_a   (sel_a),
        .sel_c   (sel_c),
        .div_a   (div_a),
        .div_c   (div_c),
        .span    (span),
        .win     (win),
        .restart (restart)
    );

    assign bank_div[0] = div_a;
    assign bank_div[1] = div_c;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        csync_phase #(.W(DW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart),
            .modulus (bank_div[g]),
            .ph      (bank_ph[g]),
            .ph_next (bank_nx[g])
        );
    end

    csync_phase #(.W(CW)) u_span (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .modulus (span),
        .ph      (span_cnt),
        .ph_next (span_nx)
    );

    // Shared-edge flags from the two bank phases.
    always_comb begin
        coinc_now  = 1'b1;
        coinc_next = 1'b1;
        for (int i = 0; i < NB; i++) begin
            coinc_now  = coinc_now  && (bank_ph[i] == '0);
            coinc_next = coinc_next && (bank_nx[i] == '0);
        end
    end

    csync_shaper #(.CW(CW)) u_shape (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .coinc_now  (coinc_now),
        .coinc_next (coinc_next),
        .cnt        (span_cnt),
        .cnt_next   (span_nx),
        .span       (span),
        .win        (win),
        .sync_n     (sync_n)
    );

    AST_SPAN_COINC: assert property (@(posedge clk) disable iff (!rst_n)
        (span_cnt == '0) == coinc_now); // R3

endmodule

// File: tb/tb_coinc_sync_gen.sv
module tb_coinc_sync_gen;

    logic       clk;
    logic       rst_n;
    logic [1:0] sel_a;
    logic [1:0] sel_c;
    logic       sync_n;

    typedef struct {
        bit    exp;
        int    t;
        string tag;
    } item_t;

    item_t q[$];
    int    n_chk;
    int    n_fail;
    int    m_t;
    logic [1:0] cur_a;
    logic [1:0] cur_c;

    coinc_sync_gen dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_a  (sel_a),
        .sel_c  (sel_c),
        .sync_n (sync_n)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic int div_of_a(input logic [1:0] s);
        case (s) 2'd0: return 4; 2'd1: return 6; 2'd2: return 8; default: return 12; endcase
    endfunction

    function automatic int div_of_c(input logic [1:0] s);
        case (s) 2'd0: return 2; 2'd1: return 4; 2'd2: return 6; default: return 8; endcase
    endfunction

    function automatic int gcd(input int a, input int b);
        while (b != 0) begin
            int r;
            r = a % b;
            a = b;
            b = r;
        end
        return a;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: apply selects at a falling edge and push n expected outputs.
    task automatic run_cfg(input logic [1:0] a, input logic [1:0] c,
                           input int n, input string tag);
        bit chg;
        int da, dc, l, w;
        chg   = (a != cur_a) || (c != cur_c);
        sel_a = a;
        sel_c = c;
        cur_a = a;
        cur_c = c;
        da = div_of_a(a);
        dc = div_of_c(c);
        l  = da * dc / gcd(da, dc);
        w  = (da < dc) ? da : dc;
        if (w > l - 1) w = l - 1;
        for (int i = 0; i < n; i++) begin
            item_t it;
            if (i == 0 && chg) m_t = 0;
            else m_t = (m_t + 1) % l;
            it.t   = m_t;
            it.exp = (m_t >= l - w) ? 1'b0 : 1'b1;
            it.tag = tag;
            q.push_back(it);
        end
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare each produced output with the scoreboard head.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_chk++;
            if (sync_n !== it.exp) begin
                n_fail++;
                $display("FAIL %s t=%0d actual=%b expected=%b", it.tag, it.t, sync_n, it.exp);
            end
        end
    end

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        n_chk  = 0;
        n_fail = 0;
        rst_n  = 1'b0;
        sel_a  = 2'd0;
        sel_c  = 2'd1;
        repeat (3) @(negedge clk);
        check(sync_n === 1'b1, "R6", sync_n, 1);
        sel_a = 2'd3;
        sel_c = 2'd3;
        @(negedge clk);
        check(sync_n === 1'b1, "R6", sync_n, 1);
        sel_a = 2'd0;
        sel_c = 2'd1;
        @(negedge clk);
        check(sync_n === 1'b1, "R6", sync_n, 1);
        cur_a = 2'd0;
        cur_c = 2'd1;
        m_t   = 0;
        rst_n = 1'b1;
        run_cfg(2'd0, 2'd1, 12, "R8");
        run_cfg(2'd2, 2'd1, 24, "R4");
        run_cfg(2'd1, 2'd0, 18, "R2");
        run_cfg(2'd1, 2'd1, 36, "R9");
        run_cfg(2'd2, 2'd0, 24, "R1");
        run_cfg(2'd1, 2'd3, 60, "R9");
        run_cfg(2'd3, 2'd0, 36, "R1");
        run_cfg(2'd0, 2'd2, 30, "R2");
        run_cfg(2'd3, 2'd3, 30, "R3");
        run_cfg(2'd3, 2'd3, 30, "R3");
        run_cfg(2'd1, 2'd3, 20, "R9");
        run_cfg(2'd0, 2'd0, 16, "R7");
        run_cfg(2'd3, 2'd3, 12, "R7");
        rst_n = 1'b0;
        @(negedge clk);
        check(sync_n === 1'b1, "R6", sync_n, 1);
        m_t   = 0;
        rst_n = 1'b1;
        run_cfg(2'd3, 2'd3, 48, "R6");
        run_cfg(2'd0, 2'd3, 24, "R4");
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule